// File: doc/BRIEF.md
# Calibration Pulse Trigger Generator

This block decides when the calibration pulser fires. It runs on the 10 MHz timing clock and watches the two fast-control mode bits, a fast gate, an external enable and an external inhibit. A request is the rising edge of the gate. The request counts only in a cycle where the mode bits mark a calibration event, the enable is high and the inhibit is low. A request that is accepted starts a programmable delay. After the delay the trigger line falls. The pulser acts on that falling edge.

The trigger line stays low for a fixed window of 200 ticks, which is about 20 µs. A window output is high for the same span. When the window ends, the trigger line returns high. The block accepts at most one request in any 1 ms span. A qualified request that comes too early is discarded and counted in a saturating counter. The delay and enable settings come in as plain inputs, held steady by whatever configures them.

Top module: `cal_trig_gen`

## Requirements
- R1: During and just after reset, `trig_n_o` is 1, `window_o` is 0 and `drop_cnt_o` is 0.
- R2: A request qualifies only when `cal_mode_i[2]` is 1 and `cal_mode_i[3]` is 0. With any other pattern, a gate edge neither fires the trigger nor changes `drop_cnt_o`.
- R3: With `enable_i` low, a gate edge neither fires the trigger nor changes `drop_cnt_o`.
- R4: With `inhibit_i` high, a gate edge neither fires the trigger nor changes `drop_cnt_o`.
- R5: A request is the low-to-high transition of `gate_i` as seen at the clock. Holding `gate_i` high produces no further requests.
- R6: Let the request be accepted at clock edge k, with `delay_i` equal to D at that edge. `trig_n_o` first reads 0 after edge k+D, so with D = 0 it is low from the very next tick.
- R7: Once low, `trig_n_o` stays low and `window_o` stays high for exactly WINDOW ticks (200 by default). Then `trig_n_o` returns to 1 and `window_o` to 0.
- R8: Let the previous accepted request be at edge a. A qualified request at any edge before a+HOLDOFF is dropped. HOLDOFF is 10000 ticks (1 ms) by default. A qualified request at edge a+HOLDOFF or later is accepted.
- R9: Each dropped request adds exactly one to `drop_cnt_o`. At its all-ones value the counter holds.
- R10: `delay_i` is used only at the acceptance edge. Changing it while a delay is running does not move the trigger edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock, one tick = 100 ns |
| rst_n | input | 1 | Asynchronous reset, active low |
| cal_mode_i | input | 2 | Fast-control mode bits 3 and 2 |
| gate_i | input | 1 | Fast gate; its rising edge is a request |
| enable_i | input | 1 | External enable, active high |
| inhibit_i | input | 1 | External inhibit, active high |
| delay_i | input | DELAY_W | Trigger delay in ticks |
| trig_n_o | output | 1 | Pulse trigger line; the falling edge is active |
| window_o | output | 1 | High during the pulse window |
| drop_cnt_o | output | DROP_W | Saturating count of requests dropped by the rate cap |

## Verification
The assertions take for granted that HOLDOFF exceeds the largest delay plus WINDOW. Under that condition a request can only arrive while the sequencer is idle or inside the holdoff, and two trigger edges stay at least HOLDOFF minus the largest delay apart. The assertions also assume that the mode, enable and inhibit inputs are stable at the clock edge where they are sampled. The stimulus changes every input on the falling clock edge only. It keeps HOLDOFF at 10000 with an 8-bit delay. It separates gate pulses by at least one low cycle, so each intended request is a clean edge.

// File: rtl/cal_trig_pkg.sv
package cal_trig_pkg;

    // Sequencer phases of the trigger generator
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DELAY = 2'd1,
        ST_PULSE = 2'd2
    } seq_state_e;

    // Mode bit pattern marking a calibration event: bit 3 low, bit 2 high
    localparam logic [3:2] CAL_MODE_MATCH = 2'b01;

endpackage

// File: rtl/cal_trig_qualify.sv
module cal_trig_qualify (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:2] cal_mode_i,
    input  logic       gate_i,
    input  logic       enable_i,
    input  logic       inhibit_i,
    output logic       req_o
);
    import cal_trig_pkg::*;

    typedef struct packed {
        logic gate;
    } qual_t;

    qual_t st_d, st_q;
    logic  allowed;

    always_comb begin
        st_d      = st_q;
        st_d.gate = gate_i;
        allowed   = (cal_mode_i == CAL_MODE_MATCH) && enable_i && !inhibit_i;
        req_o     = gate_i && !st_q.gate && allowed;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/cal_trig_holdoff.sv
module cal_trig_holdoff #(
    parameter int HOLDOFF = 10000,
    parameter int DROP_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              busy_i,
    output logic              accept_o,
    output logic [DROP_W-1:0] drop_cnt_o
);
    localparam int HOLD_W = $clog2(HOLDOFF + 1);

    typedef struct packed {
        logic [HOLD_W-1:0] hold;
        logic [DROP_W-1:0] drops;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        accept_o = req_i && !busy_i && (st_q.hold == '0);
        if (st_q.hold != '0)
            st_d.hold = st_q.hold - HOLD_W'(1);
        if (accept_o)
            st_d.hold = HOLD_W'(HOLDOFF - 1);
        else if (req_i && (st_q.drops != '1))
            st_d.drops = st_q.drops + DROP_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign drop_cnt_o = st_q.drops;
endmodule

// File: rtl/cal_trig_seq.sv
module cal_trig_seq #(
    parameter int DELAY_W = 8,
    parameter int WINDOW  = 200
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               accept_i,
    input  logic [DELAY_W-1:0] delay_i,
    output logic               busy_o,
    output logic               trig_n_o,
    output logic               window_o
);
    import cal_trig_pkg::*;

    localparam int WIN_W = $clog2(WINDOW);
    localparam int CNT_W = (DELAY_W > WIN_W) ? DELAY_W : WIN_W;

    typedef struct packed {
        seq_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic             trig_n;
        logic             window;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.state)
            ST_IDLE: begin
                if (accept_i) begin
                    if (delay_i == '0) begin
                        st_d.state  = ST_PULSE;
                        st_d.cnt    = CNT_W'(WINDOW - 1);
                        st_d.trig_n = 1'b0;
                        st_d.window = 1'b1;
                    end else begin
                        st_d.state = ST_DELAY;
                        st_d.cnt   = CNT_W'(delay_i) - CNT_W'(1);
                    end
                end
            end
            ST_DELAY: begin
                if (st_q.cnt == '0) begin
                    st_d.state  = ST_PULSE;
                    st_d.cnt    = CNT_W'(WINDOW - 1);
                    st_d.trig_n = 1'b0;
                    st_d.window = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt - CNT_W'(1);
                end
            end
            ST_PULSE: begin
                if (st_q.cnt == '0) begin
                    st_d.state  = ST_IDLE;
                    st_d.trig_n = 1'b1;
                    st_d.window = 1'b0;
                end else begin
                    st_d.cnt = st_q.cnt - CNT_W'(1);
                end
            end
            default: begin
                st_d.state  = ST_IDLE;
                st_d.trig_n = 1'b1;
                st_d.window = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.state  <= ST_IDLE;
            st_q.cnt    <= '0;
            st_q.trig_n <= 1'b1;
            st_q.window <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o   = (st_q.state != ST_IDLE);
    assign trig_n_o = st_q.trig_n;
    assign window_o = st_q.window;
endmodule

// File: rtl/cal_trig_gen.sv
module cal_trig_gen #(
    parameter int DELAY_W = 8,
    parameter int WINDOW  = 200,
    parameter int HOLDOFF = 10000,
    parameter int DROP_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [3:2]         cal_mode_i,
    input  logic               gate_i,
    input  logic               enable_i,
    input  logic               inhibit_i,
    input  logic [DELAY_W-1:0] delay_i,
    output logic               trig_n_o,
    output logic               window_o,
    output logic [DROP_W-1:0]  drop_cnt_o
);
    logic req;
    logic accept;
    logic busy;

    cal_trig_qualify u_qualify (
        .clk        (clk),
        .rst_n      (rst_n),
        .cal_mode_i (cal_mode_i),
        .gate_i     (gate_i),
        .enable_i   (enable_i),
        .inhibit_i  (inhibit_i),
        .req_o      (req)
    );

    cal_trig_holdoff #(
        .HOLDOFF (HOLDOFF),
        .DROP_W  (DROP_W)
    ) u_holdoff (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req),
        .busy_i     (busy),
        .accept_o   (accept),
        .drop_cnt_o (drop_cnt_o)
    );

    cal_trig_seq #(
        .DELAY_W (DELAY_W),
        .WINDOW  (WINDOW)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept_i (accept),
        .delay_i  (delay_i),
        .busy_o   (busy),
        .trig_n_o (trig_n_o),
        .window_o (window_o)
    );
endmodule

// File: rtl/cal_trig_gen_chk.sv
module cal_trig_gen_chk #(
    parameter int DELAY_W = 8,
    parameter int WINDOW  = 200,
    parameter int HOLDOFF = 10000,
    parameter int DROP_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:2]        cal_mode_i,
    input logic              gate_i,
    input logic              enable_i,
    input logic              inhibit_i,
    input logic              trig_n_o,
    input logic              window_o,
    input logic [DROP_W-1:0] drop_cnt_o
);
    localparam longint MIN_GAP = longint'(HOLDOFF) - ((longint'(1) << DELAY_W) - 1);

    logic        trig_prev_q;
    logic        seen_q;
    logic [31:0] gap_q;
    logic [31:0] len_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trig_prev_q <= 1'b1;
            seen_q      <= 1'b0;
            gap_q       <= '0;
            len_q       <= '0;
        end else begin
            trig_prev_q <= trig_n_o;
            len_q       <= window_o ? len_q + 32'd1 : 32'd0;
            if (trig_prev_q && !trig_n_o) begin
                seen_q <= 1'b1;
                gap_q  <= 32'd1;
            end else if (gap_q != '1) begin
                gap_q <= gap_q + 32'd1;
            end
        end
    end

    // R7: the window lasts exactly WINDOW ticks
    p_window_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(window_o) |-> (len_q == 32'(WINDOW)));

    // R8: trigger edges keep the rate cap
    p_rate_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_prev_q && !trig_n_o && seen_q) |-> (longint'(gap_q) >= MIN_GAP));

    // R9: the drop count steps by one and only upward
    p_drop_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_cnt_o != $past(drop_cnt_o)) |-> (drop_cnt_o == $past(drop_cnt_o) + DROP_W'(1)));

    // R9: the drop count holds at all ones
    p_drop_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(drop_cnt_o) == '1) |-> (drop_cnt_o == '1));

    // R2: a drop needs the calibration mode pattern
    p_drop_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_cnt_o != $past(drop_cnt_o)) |-> ($past(cal_mode_i) == 2'b01));

    // R4: a drop needs enable high and inhibit low
    p_drop_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_cnt_o != $past(drop_cnt_o)) |-> ($past(enable_i) && !$past(inhibit_i)));

    // R5: a drop needs a gate rising edge
    p_drop_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_cnt_o != $past(drop_cnt_o)) |-> ($past(gate_i) && !$past(gate_i, 2)));
endmodule

bind cal_trig_gen cal_trig_gen_chk #(
    .DELAY_W (DELAY_W),
    .WINDOW  (WINDOW),
    .HOLDOFF (HOLDOFF),
    .DROP_W  (DROP_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cal_mode_i (cal_mode_i),
    .gate_i     (gate_i),
    .enable_i   (enable_i),
    .inhibit_i  (inhibit_i),
    .trig_n_o   (trig_n_o),
    .window_o   (window_o),
    .drop_cnt_o (drop_cnt_o)
);

// File: tb/cal_trig_gen_test.sv
module cal_trig_gen_test;
    localparam int DELAY_W  = 8;
    localparam int WINDOW   = 200;
    localparam int HOLDOFF  = 10000;
    localparam int DROP_W   = 8;
    localparam int DROP_MAX = (1 << DROP_W) - 1;

    logic               clk = 1'b0;
    logic               rst_n;
    logic [3:2]         cal_mode_i;
    logic               gate_i;
    logic               enable_i;
    logic               inhibit_i;
    logic [DELAY_W-1:0] delay_i;
    logic               trig_n_o;
    logic               window_o;
    logic [DROP_W-1:0]  drop_cnt_o;

    int cyc = 0;
    int checks = 0;
    int failures = 0;
    int exp_drop = 0;
    int acc = 0;
    int acc_prev = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    cal_trig_gen #(
        .DELAY_W (DELAY_W),
        .WINDOW  (WINDOW),
        .HOLDOFF (HOLDOFF),
        .DROP_W  (DROP_W)
    ) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cal_mode_i (cal_mode_i),
        .gate_i     (gate_i),
        .enable_i   (enable_i),
        .inhibit_i  (inhibit_i),
        .delay_i    (delay_i),
        .trig_n_o   (trig_n_o),
        .window_o   (window_o),
        .drop_cnt_o (drop_cnt_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Gate edge sampled at the next rising clock; returns at the following negedge
    task automatic fire(input bit hold);
        gate_i = 1'b1;
        @(negedge clk);
        acc = cyc;
        if (!hold) gate_i = 1'b0;
    endtask

    task automatic wait_until(input int target);
        while (cyc < target) @(negedge clk);
    endtask

    task automatic expect_pulse(input int d, input string tag);
        int n;
        if (d > 0) begin
            repeat (d - 1) @(negedge clk);
            check({tag, " high before delay ends"}, int'(trig_n_o), 1);
            @(negedge clk);
        end
        check({tag, " trigger falls"}, int'(trig_n_o), 0);
        check("R7 window high", int'(window_o), 1);
        n = 0;
        while (trig_n_o == 1'b0 && n < 1000) begin
            n++;
            @(negedge clk);
        end
        check("R7 window length", n, WINDOW);
        check("R7 window low after", int'(window_o), 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; cal_mode_i = 2'b00; gate_i = 1'b0;
        enable_i = 1'b0; inhibit_i = 1'b0; delay_i = '0;
        repeat (3) @(negedge clk);
        check("R1 trig idle", int'(trig_n_o), 1);
        check("R1 window idle", int'(window_o), 0);
        check("R1 drop zero", int'(drop_cnt_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 trig after release", int'(trig_n_o), 1);
    endtask

    task automatic t_qualifiers();
        logic [3:2] bad [3] = '{2'b00, 2'b11, 2'b10};
        enable_i = 1'b1; inhibit_i = 1'b0; delay_i = '0;
        foreach (bad[i]) begin
            cal_mode_i = bad[i];
            fire(1'b0);
            repeat (3) @(negedge clk);
            check("R2 wrong mode no trigger", int'(trig_n_o), 1);
            check("R2 wrong mode no drop", int'(drop_cnt_o), exp_drop);
        end
        cal_mode_i = 2'b01; enable_i = 1'b0;
        fire(1'b0);
        repeat (3) @(negedge clk);
        check("R3 disabled no trigger", int'(trig_n_o), 1);
        check("R3 disabled no drop", int'(drop_cnt_o), exp_drop);
        enable_i = 1'b1; inhibit_i = 1'b1;
        fire(1'b0);
        repeat (3) @(negedge clk);
        check("R4 inhibited no trigger", int'(trig_n_o), 1);
        check("R4 inhibited no drop", int'(drop_cnt_o), exp_drop);
        inhibit_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_zero_delay_held_gate();
        cal_mode_i = 2'b01; delay_i = '0;
        fire(1'b1);
        acc_prev = acc;
        expect_pulse(0, "R6 zero delay");
        repeat (300) @(negedge clk);
        check("R5 held gate no retrigger", int'(trig_n_o), 1);
        check("R5 held gate no drop", int'(drop_cnt_o), exp_drop);
        gate_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_holdoff_edge();
        delay_i = 8'd37;
        wait_until(acc_prev + HOLDOFF - 2);
        fire(1'b0);
        exp_drop++;
        check("R8 one tick early dropped", int'(drop_cnt_o), exp_drop);
        check("R9 drop counted", int'(trig_n_o), 1);
        wait_until(acc_prev + HOLDOFF);
        fire(1'b0);
        acc_prev = acc;
        expect_pulse(37, "R6 delay 37");
        check("R8 late request accepted", int'(drop_cnt_o), exp_drop);
    endtask

    task automatic t_exact_and_delay_change();
        delay_i = 8'd20;
        wait_until(acc_prev + HOLDOFF - 1);
        gate_i = 1'b1;
        @(negedge clk);
        acc_prev = cyc;
        gate_i = 1'b0;
        delay_i = 8'd200;
        expect_pulse(20, "R10 delay latched");
        check("R8 exact holdoff accepted", int'(drop_cnt_o), exp_drop);
    endtask

    task automatic t_saturate();
        for (int i = 0; i < 260; i++) begin
            fire(1'b0);
            @(negedge clk);
            if (exp_drop < DROP_MAX) exp_drop++;
            if (i == 9) check("R9 drop count mid", int'(drop_cnt_o), exp_drop);
        end
        check("R9 drop saturates", int'(drop_cnt_o), DROP_MAX);
        check("R8 drops do not fire", int'(trig_n_o), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_qualifiers();
        t_zero_delay_held_gate();
        t_holdoff_edge();
        t_exact_and_delay_change();
        t_saturate();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule